// File: doc/BRIEF.md
# Multi-Lane Sample Serializer

This block turns parallel converter samples into bit streams. Every channel delivers a 14-bit word in offset-binary form. On a sample strobe the block takes the words of all channels in the same cycle. It then shifts each word out on that channel's own pair of lanes, and all channels run in step. A frame marker and a bit-rate enable go out with the data, so a receiver can find the bit periods and the word boundaries.

Three settings are read when the strobe arrives, and they stay fixed for the whole frame:

- **Lane mode.** In one-lane mode the word goes out on a single lane. In two-lane mode it is split over two lanes, which halves the number of bit periods per word.
- **Bit order.** The word can go out MSB first or LSB first.
- **Output coding.** The word can go out as straight binary or as two's complement.

The whole design runs in one fast clock domain. One bit period lasts `CLK_PER_BIT` clocks.

Top module: `adc_lane_serializer`

## Requirements
- R1: While reset is held, and after it until the first sample strobe, every lane output, `frame_mark` and `bit_en` are 0. Reset is synchronous and active high.
- R2: A strobe on a rising edge captures the words of all channels. The first bit period of the frame is on the outputs from that edge onward. Each bit period lasts `CLK_PER_BIT` clocks, and `bit_en` is 1 only in the first clock of each bit period.
- R3: With `cfg_two_lane`=1 a frame has 7 bit periods. In period p, lane `lane_data[2*ch]` carries bit position 2p of the ordered sequence and `lane_data[2*ch+1]` carries position 2p+1.
- R4: With `cfg_two_lane`=0 a frame has 14 bit periods. Period p carries sequence position p on `lane_data[2*ch]`, and `lane_data[2*ch+1]` stays 0.
- R5: With `cfg_lsb_first`=0, sequence position k is bit 13-k of the coded word. With `cfg_lsb_first`=1, position k is bit k.
- R6: With `cfg_twos_comp`=0 the coded word equals the input word. With `cfg_twos_comp`=1, bit 13 of the input word is inverted and the other bits are kept.
- R7: `frame_mark` is 1 during the first ceil(L/2) bit periods of a frame of L periods, and 0 for the rest: 4 of 7 periods, or 7 of 14.
- R8: Changes on `sample_data` or on any configuration input between strobes have no effect on the frame already under way.
- R9: A strobe that arrives during a frame abandons that frame. The new frame starts on the next edge exactly as in R2.
- R10: When a frame ends and no strobe has come, all lanes, `frame_mark` and `bit_en` read 0 until the next strobe.
- R11: A strobe in the last clock of a frame makes the next frame follow with no idle clock between the two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock; every register uses its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sample_stb | input | 1 | Captures the samples and settings and starts a frame |
| sample_data | input | NCH*W | Offset-binary words; channel ch is in bits [ch*W +: W] |
| cfg_two_lane | input | 1 | 1: two lanes per channel, 0: one lane |
| cfg_lsb_first | input | 1 | 1: LSB first, 0: MSB first |
| cfg_twos_comp | input | 1 | 1: two's complement output, 0: straight binary |
| lane_data | output | 2*NCH | Serial lanes; bit 2*ch is lane 0 and bit 2*ch+1 is lane 1 of channel ch |
| frame_mark | output | 1 | Word-alignment marker, high in the first half of each frame |
| bit_en | output | 1 | High in the first clock of each bit period |

## Verification
Every output comes straight from a register that the strobe edge loads. The first bit period is therefore due on the first falling edge after the strobe edge, and period p is due `p*CLK_PER_BIT` clocks after that. The bench drives all inputs on falling edges and samples on falling edges. It walks a cycle counter through each frame and derives the expected lane bits, marker and enable from that counter. For chained and aborted frames, the next strobe is raised at the same falling edge where the previous frame's last check was made. Idle zeros are checked one clock after the final period of a frame.

// File: rtl/adc_ser_pkg.sv
package adc_ser_pkg;

   // Frame settings, captured together on a sample strobe.
   typedef struct packed {
      logic two_lane;
      logic lsb_first;
      logic twos_comp;
   } ser_cfg_t;

   // Number of bit periods in a frame for a word of width w.
   function automatic int frame_periods(input int w, input logic two_lane);
      return two_lane ? (w + 1) / 2 : w;
   endfunction

   // Number of periods at the start of the frame during which the marker is high.
   function automatic int mark_periods(input int w, input logic two_lane);
      return (frame_periods(w, two_lane) + 1) / 2;
   endfunction

endpackage

// File: rtl/adc_ser_coder.sv
module adc_ser_coder
   import adc_ser_pkg::*;
#(
   parameter int W = 14
) (
   input  logic [W-1:0] word_in,
   input  ser_cfg_t     cfg,
   output logic [W-1:0] seq_out
);
   logic [W-1:0] coded;

   // Two's complement from offset binary: invert the top bit only.
   always_comb begin
      coded = word_in;
      if (cfg.twos_comp) coded[W-1] = ~word_in[W-1];
   end

   // seq_out[k] is the k-th bit to leave the channel.
   for (genvar k = 0; k < W; k++) begin : g_ord
      assign seq_out[k] = cfg.lsb_first ? coded[k] : coded[W-1-k];
   end
endmodule

// File: rtl/adc_ser_lane.sv
module adc_ser_lane #(
   parameter int W = 14
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         load,
   input  logic [W-1:0] seq_in,
   input  logic         shift_en,
   input  logic         two_lane_q,
   output logic [1:0]   lanes
);
   logic [W-1:0] sr_q;

   // Zeros shift in from the top, so the register is empty once a frame ends.
   always_ff @(posedge clk) begin
      if (rst) begin
         sr_q <= '0;
      end else if (load) begin
         sr_q <= seq_in;
      end else if (shift_en) begin
         if (two_lane_q) sr_q <= {2'b00, sr_q[W-1:2]};
         else            sr_q <= {1'b0,  sr_q[W-1:1]};
      end
   end

   assign lanes[0] = sr_q[0];
   assign lanes[1] = two_lane_q & sr_q[1];
endmodule

// File: rtl/adc_ser_timer.sv
module adc_ser_timer
   import adc_ser_pkg::*;
#(
   parameter int W           = 14,
   parameter int CLK_PER_BIT = 2
) (
   input  logic     clk,
   input  logic     rst,
   input  logic     stb,
   input  ser_cfg_t cfg_in,
   output ser_cfg_t cfg_q,
   output logic     active,
   output logic     bit_en,
   output logic     shift_en,
   output logic     frame_mark
);
   localparam int PW = $clog2(W + 1);
   localparam logic [PW-1:0] LAST_TWO = PW'(frame_periods(W, 1'b1) - 1);
   localparam logic [PW-1:0] LAST_ONE = PW'(frame_periods(W, 1'b0) - 1);
   localparam logic [PW-1:0] MARK_TWO = PW'(mark_periods(W, 1'b1));
   localparam logic [PW-1:0] MARK_ONE = PW'(mark_periods(W, 1'b0));

   logic [PW-1:0] per_q;
   logic          active_q;
   logic          div_first;
   logic          div_last;
   logic [PW-1:0] last_per;
   logic [PW-1:0] mark_lim;

   // Divider: picks the first and last clock of each bit period.
   if (CLK_PER_BIT == 1) begin : g_div_none
      assign div_first = 1'b1;
      assign div_last  = 1'b1;
   end else begin : g_div_cnt
      localparam int DW = $clog2(CLK_PER_BIT);
      localparam logic [DW-1:0] DIV_END = DW'(CLK_PER_BIT - 1);
      logic [DW-1:0] div_q;
      always_ff @(posedge clk) begin
         if (rst || stb || !active_q) div_q <= '0;
         else if (div_q == DIV_END)   div_q <= '0;
         else                         div_q <= div_q + 1'b1;
      end
      assign div_first = (div_q == '0);
      assign div_last  = (div_q == DIV_END);
   end

   assign last_per = cfg_q.two_lane ? LAST_TWO : LAST_ONE;
   assign mark_lim = cfg_q.two_lane ? MARK_TWO : MARK_ONE;

   always_ff @(posedge clk) begin
      if (rst) begin
         active_q <= 1'b0;
         per_q    <= '0;
         cfg_q    <= '0;
      end else if (stb) begin
         active_q <= 1'b1;
         per_q    <= '0;
         cfg_q    <= cfg_in;
      end else if (active_q && div_last) begin
         if (per_q == last_per) begin
            active_q <= 1'b0;
            per_q    <= '0;
         end else begin
            per_q <= per_q + 1'b1;
         end
      end
   end

   assign active     = active_q;
   assign bit_en     = active_q & div_first;
   assign shift_en   = active_q & div_last & ~stb;
   assign frame_mark = active_q & (per_q < mark_lim);
endmodule

// File: rtl/adc_lane_serializer.sv
module adc_lane_serializer
   import adc_ser_pkg::*;
#(
   parameter int NCH         = 4,
   parameter int W           = 14,
   parameter int CLK_PER_BIT = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             sample_stb,
   input  logic [NCH*W-1:0] sample_data,
   input  logic             cfg_two_lane,
   input  logic             cfg_lsb_first,
   input  logic             cfg_twos_comp,
   output logic [2*NCH-1:0] lane_data,
   output logic             frame_mark,
   output logic             bit_en
);
   if (NCH < 1) begin : g_bad_nch
      $error("NCH must be at least 1");
   end
   if (W < 4) begin : g_bad_w
      $error("W must be at least 4");
   end
   if (CLK_PER_BIT < 1) begin : g_bad_cpb
      $error("CLK_PER_BIT must be at least 1");
   end

   ser_cfg_t cfg_live;
   ser_cfg_t cfg_q;
   logic     active;
   logic     shift_en;
   logic     two_lane_q;

   assign cfg_live   = '{two_lane: cfg_two_lane, lsb_first: cfg_lsb_first,
                         twos_comp: cfg_twos_comp};
   assign two_lane_q = cfg_q.two_lane;

   adc_ser_timer #(.W(W), .CLK_PER_BIT(CLK_PER_BIT)) u_timer (
      .clk        (clk),
      .rst        (rst),
      .stb        (sample_stb),
      .cfg_in     (cfg_live),
      .cfg_q      (cfg_q),
      .active     (active),
      .bit_en     (bit_en),
      .shift_en   (shift_en),
      .frame_mark (frame_mark)
   );

   for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
      logic [W-1:0] seq;
      adc_ser_coder #(.W(W)) u_coder (
         .word_in (sample_data[ch*W +: W]),
         .cfg     (cfg_live),
         .seq_out (seq)
      );
      adc_ser_lane #(.W(W)) u_lane (
         .clk        (clk),
         .rst        (rst),
         .load       (sample_stb),
         .seq_in     (seq),
         .shift_en   (shift_en),
         .two_lane_q (two_lane_q),
         .lanes      (lane_data[2*ch +: 2])
      );
   end
endmodule

// File: rtl/adc_ser_checker.sv
module adc_ser_checker #(
   parameter int NCH = 4
) (
   input logic             clk,
   input logic             rst,
   input logic             sample_stb,
   input logic [2*NCH-1:0] lane_data,
   input logic             frame_mark,
   input logic             bit_en,
   input logic             active,
   input logic             two_lane_q
);
   function automatic logic [2*NCH-1:0] odd_mask();
      logic [2*NCH-1:0] m = '0;
      for (int i = 0; i < NCH; i++) m[2*i+1] = 1'b1;
      return m;
   endfunction

   localparam logic [2*NCH-1:0] ODD = odd_mask();

   p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (lane_data == '0) && !frame_mark && !bit_en);

   p_start_r2: assert property (@(posedge clk) disable iff (rst)
      sample_stb |=> bit_en && frame_mark);

   p_hold_r2: assert property (@(posedge clk) disable iff (rst)
      (active && !bit_en && !$past(rst)) |-> $stable(lane_data));

   p_lane1_zero_r4: assert property (@(posedge clk) disable iff (rst)
      !two_lane_q |-> ((lane_data & ODD) == '0));

   p_mark_rise_r7: assert property (@(posedge clk) disable iff (rst)
      $rose(frame_mark) |-> bit_en);
endmodule

bind adc_lane_serializer adc_ser_checker #(.NCH(NCH)) u_checker (
   .clk        (clk),
   .rst        (rst),
   .sample_stb (sample_stb),
   .lane_data  (lane_data),
   .frame_mark (frame_mark),
   .bit_en     (bit_en),
   .active     (active),
   .two_lane_q (two_lane_q)
);

// File: tb/test_adc_lane_serializer.sv
`timescale 1ns/1ps
module test_adc_lane_serializer;
   localparam int NCH = 4;
   localparam int W   = 14;
   localparam int CPB = 2;

   logic             clk = 1'b0;
   logic             rst;
   logic             sample_stb;
   logic [NCH*W-1:0] sample_data;
   logic             cfg_two_lane, cfg_lsb_first, cfg_twos_comp;
   logic [2*NCH-1:0] lane_data;
   logic             frame_mark, bit_en;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   adc_lane_serializer #(.NCH(NCH), .W(W), .CLK_PER_BIT(CPB)) i_adc_lane_serializer (
      .clk(clk), .rst(rst), .sample_stb(sample_stb), .sample_data(sample_data),
      .cfg_two_lane(cfg_two_lane), .cfg_lsb_first(cfg_lsb_first),
      .cfg_twos_comp(cfg_twos_comp), .lane_data(lane_data),
      .frame_mark(frame_mark), .bit_en(bit_en)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   // Expected bit on lane l of a channel in period p (R3..R6).
   function automatic logic exp_lane(input logic [W-1:0] w, input logic two,
                                     input logic lsb, input logic twos,
                                     input int p, input int l);
      logic [W-1:0] code = w;
      int k;
      if (twos) code[W-1] = ~w[W-1];
      if (two) k = 2*p + l;
      else if (l == 1) return 1'b0;
      else k = p;
      if (k >= W) return 1'b0;
      return lsb ? code[k] : code[W-1-k];
   endfunction

   // Starts a frame at the current falling edge; returns after cycle stop_at
   // (chain or abort), or with stop_at < 0 runs the frame out and checks idle.
   task automatic run_frame(input logic [NCH*W-1:0] d, input logic two,
                            input logic lsb, input logic twos, input int stop_at,
                            input bit scramble, input string tag);
      int len = two ? (W+1)/2 : W;
      int half = (len+1)/2;
      logic [2*NCH-1:0] exp_l;
      string lreq = two ? "R3/R5/R6" : "R4/R5/R6";
      sample_stb = 1'b1; sample_data = d;
      cfg_two_lane = two; cfg_lsb_first = lsb; cfg_twos_comp = twos;
      for (int i = 0; i < len*CPB; i++) begin
         @(negedge clk);
         sample_stb = 1'b0;
         if (scramble) begin
            sample_data   = {$urandom, $urandom};
            cfg_two_lane  = ~two; cfg_lsb_first = ~lsb; cfg_twos_comp = ~twos;
         end
         for (int ch = 0; ch < NCH; ch++)
            for (int l = 0; l < 2; l++)
               exp_l[2*ch+l] = exp_lane(d[ch*W +: W], two, lsb, twos, i/CPB, l);
         check(lane_data == exp_l, {lreq, " ", tag}, 32'(lane_data), 32'(exp_l));
         check(frame_mark == ((i/CPB) < half), {"R7 ", tag}, 32'(frame_mark),
               32'((i/CPB) < half));
         check(bit_en == ((i % CPB) == 0), {"R2 ", tag}, 32'(bit_en),
               32'((i % CPB) == 0));
         if (i == stop_at) return;
      end
      for (int j = 0; j < 2; j++) begin
         @(negedge clk);
         check(lane_data == '0 && !frame_mark && !bit_en, "R10 idle",
               {22'(0), bit_en, frame_mark, lane_data}, 32'(0));
      end
   endtask

   function automatic logic [NCH*W-1:0] rnd_data();
      logic [NCH*W-1:0] d;
      for (int ch = 0; ch < NCH; ch++) d[ch*W +: W] = W'($urandom);
      return d;
   endfunction

   initial begin
      void'($urandom(32'd20240611));
      rst = 1'b1; sample_stb = 1'b0; sample_data = '0;
      cfg_two_lane = 1'b1; cfg_lsb_first = 1'b0; cfg_twos_comp = 1'b0;
      repeat (3) @(negedge clk);
      check(lane_data == '0 && !frame_mark && !bit_en, "R1 in reset",
            32'(lane_data), 32'(0));
      rst = 1'b0;
      sample_data = rnd_data();
      for (int j = 0; j < 3; j++) begin
         @(negedge clk);
         check(lane_data == '0 && !frame_mark && !bit_en, "R1 before strobe",
               {22'(0), bit_en, frame_mark, lane_data}, 32'(0));
      end

      // Directed: every setting combination with corner words.
      for (int c = 0; c < 8; c++) begin
         run_frame({14'h0000, 14'h3FFF, 14'h2000, 14'h1555},
                   c[0], c[1], c[2], -1, 1'b0, "directed");
         run_frame({14'h1FFF, 14'h0001, 14'h2AAA, 14'h3E01},
                   c[0], c[1], c[2], -1, 1'b0, "directed");
      end

      // Back-to-back frames (R11), settings changing frame to frame.
      for (int n = 0; n < 20; n++) begin
         logic two = 1'($urandom);
         int len = two ? (W+1)/2 : W;
         run_frame(rnd_data(), two, 1'($urandom), 1'($urandom), len*CPB-1,
                   1'b0, "R11 chained");
      end
      run_frame(rnd_data(), 1'b1, 1'b0, 1'b1, -1, 1'b0, "R11 tail");

      // Inputs disturbed mid-frame (R8).
      for (int n = 0; n < 8; n++)
         run_frame(rnd_data(), 1'($urandom), 1'($urandom), 1'($urandom), -1,
                   1'b1, "R8 ignored");

      // Frames abandoned by an early strobe (R9).
      for (int n = 0; n < 10; n++) begin
         logic two = 1'($urandom);
         int len = two ? (W+1)/2 : W;
         run_frame(rnd_data(), two, 1'($urandom), 1'($urandom),
                   int'($urandom % (len*CPB-1)), 1'b0, "R9 aborted");
      end
      run_frame(rnd_data(), 1'b0, 1'b1, 1'b0, -1, 1'b0, "R9 after abort");

      // Random mix.
      for (int n = 0; n < 40; n++)
         run_frame(rnd_data(), 1'($urandom), 1'($urandom), 1'($urandom), -1,
                   1'($urandom), "random");

      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++; errors++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule